// File: doc/BRIEF.md
# Configurable Serial Port with Line-Driver Enable

This block is an asynchronous serial transmitter and receiver. Software or a neighbouring block sets the frame shape at run time: 7 or 8 data bits, parity on or off (odd or even), and one or two stop bits. A byte handed over on a valid/ready handshake leaves on `txd`. Bytes arriving on `rxd` are placed in a single holding register together with their parity and framing status.

Hardware flow control uses two active-low lines. `cts_n` from the far end gates the start of each new transmit frame. `rts_n` tells the far end to pause while the holding register is occupied. `tx_active` covers each transmit frame from its start bit to the end of its last stop bit, so it can drive the enable pin of a half-duplex RS485 line driver directly.

When every configuration input is tied to zero, the block runs as 8 data bits, no parity, one stop bit, flow control on, at 9600 baud.

Top module: `uart485_core`

## Requirements
- R1: A frame is a low start bit, the data bits least significant first, an optional parity bit, then high stop bits. Each bit lasts 16 tick periods. The tick period is `baud_div` clocks when `baud_div` is non-zero, so the bit time is 16·`baud_div` clocks.
- R2: `cfg_data7`=1 selects 7 data bits (bit 7 of `tx_data` is not sent, and `rx_data[7]` reads 0). `cfg_data7`=0 selects 8 data bits.
- R3: `cfg_par_en`=1 adds a parity bit after the data bits. With `cfg_par_odd`=0 the parity bit makes the count of ones across data and parity even. With `cfg_par_odd`=1 that count is odd.
- R4: `cfg_stop2`=1 sends two stop bits. `cfg_stop2`=0 sends one.
- R5: With all configuration inputs at zero, the frame is 8 data bits, no parity and one stop bit, with flow control on. A `baud_div` of 0 selects a tick period of CLK_HZ/(16·9600) clocks, which is 312 clocks at the default 48 MHz.
- R6: With flow control on (`cfg_flow_off`=0), `tx_ready` stays low and no frame starts while `cts_n` is high. A frame that has already started always completes, even if `cts_n` rises during it.
- R7: `tx_active` is high from the start bit through the end of the last stop bit, and low otherwise. `txd` is high whenever no frame is in progress.
- R8: The receiver counts at 16 ticks per bit and samples each bit at its centre. A low pulse that has ended before the middle of the start bit produces no byte.
- R9: If the first stop bit is sampled low, `rx_ferr` is set for that byte.
- R10: If parity is enabled and the received parity bit does not match, `rx_perr` is set for that byte.
- R11: `rx_valid`, `rx_data` and the two error flags hold until `rx_ack` is pulsed. With flow control on, `rts_n` is high while `rx_valid` is high. In every other case `rts_n` is low.
- R12: `tx_ready` is high only while the transmitter is idle and flow control permits a start. A byte is accepted on a clock where `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clocks per 16x tick; 0 selects the 9600-baud default |
| cfg_data7 | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_flow_off | input | 1 | 1 = ignore CTS and keep RTS low |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial transmit line |
| tx_active | output | 1 | Driver enable, high across each transmit frame |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | Holding register occupied |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity error for the held byte |
| rx_ferr | output | 1 | Framing error for the held byte |
| rx_ack | input | 1 | Consumer has read the held byte |

## Verification
On every cycle, the assertions check the following:
- a frame never starts while CTS is blocking;
- `txd` changes only on tick boundaries once a frame has begun;
- the driver enable only drops after a high line;
- a receive frame proceeds only when the start bit is still low at its centre;
- the held byte stays put until it is acknowledged;
- `tx_ready` never coincides with an active frame.

Only the bench scenarios can show the rest: the actual bit order, the parity values, the stop-bit counts, the default frame timing, the error flags for corrupted frames, and the rejection of a short start glitch.

// File: rtl/uart485_pkg.sv
package uart485_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned OVERSMP = 16;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PAR,
    FS_STOP
  } frame_st_e;

  typedef struct packed {
    logic data7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_cfg_t;
endpackage

// File: rtl/uart485_tick.sv
module uart485_tick #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DEF_DIV = 312
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] DEF_V = DIV_W'(DEF_DIV);

  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    period = (baud_div == '0) ? DEF_V : baud_div;
    tick   = (cnt_q >= period - DIV_W'(1));
    cnt_d  = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart485_tx.sv
module uart485_tx
  import uart485_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              flow_en,
  input  logic              cts_s,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd,
  output logic              tx_active
);
  frame_st_e         st_q, st_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [2:0]        bit_q, bit_d;
  logic [4:0]        sub_q, sub_d;
  logic              par_q, par_d;
  logic [BYTE_W-1:0] masked;
  logic [2:0]        last_bit;
  logic [4:0]        stop_end;

  always_comb begin
    masked   = cfg.data7 ? {1'b0, tx_data[BYTE_W-2:0]} : tx_data;
    last_bit = cfg.data7 ? 3'd6 : 3'd7;
    stop_end = cfg.stop2 ? 5'd31 : 5'd15;
    tx_ready = (st_q == FS_IDLE) && (!flow_en || !cts_s);
    st_d  = st_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    sub_d = sub_q;
    par_d = par_q;
    if (st_q == FS_IDLE) begin
      if (tx_valid && tx_ready) begin
        st_d  = FS_START;
        sh_d  = masked;
        par_d = (^masked) ^ cfg.par_odd;
        sub_d = '0;
        bit_d = '0;
      end
    end else if (tick) begin
      sub_d = sub_q + 5'd1;
      unique case (st_q)
        FS_START: if (sub_q == 5'd15) begin
          st_d  = FS_DATA;
          sub_d = '0;
        end
        FS_DATA: if (sub_q == 5'd15) begin
          sub_d = '0;
          sh_d  = sh_q >> 1;
          if (bit_q == last_bit) st_d = cfg.par_en ? FS_PAR : FS_STOP;
          else                   bit_d = bit_q + 3'd1;
        end
        FS_PAR: if (sub_q == 5'd15) begin
          st_d  = FS_STOP;
          sub_d = '0;
        end
        FS_STOP: if (sub_q == stop_end) begin
          st_d  = FS_IDLE;
          sub_d = '0;
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      sh_q  <= '0;
      bit_q <= '0;
      sub_q <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      sub_q <= sub_d;
      par_q <= par_d;
    end
  end

  always_comb begin
    unique case (st_q)
      FS_START: txd = 1'b0;
      FS_DATA:  txd = sh_q[0];
      FS_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
    tx_active = (st_q != FS_IDLE);
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_START && $past(st_q) == FS_IDLE && $past(flow_en)) |-> !$past(cts_s)); // R6
  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FS_IDLE && $past(st_q) != FS_IDLE && !$past(tick)) |-> $stable(txd)); // R1
  AST_ACTIVE_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> $past(txd)); // R7
endmodule

// File: rtl/uart485_rx.sv
module uart485_rx
  import uart485_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              rxd_s,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  frame_st_e         st_q, st_d;
  logic [3:0]        sub_q, sub_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              acc_q, acc_d;
  logic              done_d, perr_d, ferr_d;
  logic [BYTE_W-1:0] data_d;
  logic [2:0]        last_bit;

  always_comb begin
    last_bit = cfg.data7 ? 3'd6 : 3'd7;
    st_d   = st_q;
    sub_d  = sub_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    acc_d  = acc_q;
    done_d = 1'b0;
    data_d = data;
    perr_d = perr;
    ferr_d = ferr;
    if (st_q == FS_IDLE) begin
      if (!rxd_s) begin
        st_d  = FS_START;
        sub_d = '0;
      end
    end else if (tick) begin
      sub_d = sub_q + 4'd1;
      unique case (st_q)
        FS_START: if (sub_q == 4'd7) begin
          sub_d = '0;
          bit_d = '0;
          acc_d = 1'b0;
          st_d  = rxd_s ? FS_IDLE : FS_DATA;
        end
        FS_DATA: if (sub_q == 4'd15) begin
          sub_d = '0;
          sh_d  = {rxd_s, sh_q[BYTE_W-1:1]};
          acc_d = acc_q ^ rxd_s;
          if (bit_q == last_bit) st_d = cfg.par_en ? FS_PAR : FS_STOP;
          else                   bit_d = bit_q + 3'd1;
        end
        FS_PAR: if (sub_q == 4'd15) begin
          sub_d = '0;
          acc_d = acc_q ^ rxd_s;
          st_d  = FS_STOP;
        end
        FS_STOP: if (sub_q == 4'd15) begin
          sub_d  = '0;
          st_d   = FS_IDLE;
          done_d = 1'b1;
          data_d = cfg.data7 ? {1'b0, sh_q[BYTE_W-1:1]} : sh_q;
          perr_d = cfg.par_en && (acc_q ^ cfg.par_odd);
          ferr_d = !rxd_s;
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      sub_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      acc_q <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      acc_q <= acc_d;
      done  <= done_d;
      data  <= data_d;
      perr  <= perr_d;
      ferr  <= ferr_d;
    end
  end

  AST_START_STILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_DATA && $past(st_q) == FS_START) |-> !$past(rxd_s)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/uart485_core.sv
module uart485_core
  import uart485_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 48_000_000,
  parameter int unsigned DEF_BAUD = 9600,
  parameter int unsigned DIV_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              cfg_data7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              cfg_flow_off,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd,
  output logic              tx_active,
  input  logic              cts_n,
  output logic              rts_n,
  input  logic              rxd,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  input  logic              rx_ack
);
  localparam int unsigned DEF_DIV = CLK_HZ / (OVERSMP * DEF_BAUD);

  frame_cfg_t        cfg;
  logic              tick, flow_en;
  logic [1:0]        rxd_sync, cts_sync;
  logic              rx_done, rx_pe, rx_fe;
  logic [BYTE_W-1:0] rx_byte;
  logic              valid_d, perr_d, ferr_d;
  logic [BYTE_W-1:0] hold_d;

  always_comb begin
    cfg     = '{data7: cfg_data7, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
    flow_en = !cfg_flow_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_sync <= 2'b11;
      cts_sync <= 2'b11;
    end else begin
      rxd_sync <= {rxd_sync[0], rxd};
      cts_sync <= {cts_sync[0], cts_n};
    end
  end

  uart485_tick #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tick(tick)
  );

  uart485_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .flow_en(flow_en),
    .cts_s(cts_sync[1]), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .txd(txd), .tx_active(tx_active)
  );

  uart485_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .rxd_s(rxd_sync[1]),
    .done(rx_done), .data(rx_byte), .perr(rx_pe), .ferr(rx_fe)
  );

  always_comb begin
    valid_d = rx_valid;
    hold_d  = rx_data;
    perr_d  = rx_perr;
    ferr_d  = rx_ferr;
    if (rx_done) begin
      valid_d = 1'b1;
      hold_d  = rx_byte;
      perr_d  = rx_pe;
      ferr_d  = rx_fe;
    end else if (rx_ack) begin
      valid_d = 1'b0;
    end
    rts_n = flow_en && rx_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= valid_d;
      rx_data  <= hold_d;
      rx_perr  <= perr_d;
      rx_ferr  <= ferr_d;
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack && !rx_done) |=> (rx_valid && $stable(rx_data))); // R11
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !tx_active); // R12
endmodule

// File: tb/sim_uart485_core.sv
module sim_uart485_core;
  localparam int CLK_HZ  = 48_000_000;
  localparam int DEF_PER = CLK_HZ / (16 * 9600);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] baud_div = '0;
  logic cfg_data7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_flow_off = 0;
  logic tx_valid = 0;
  logic [7:0] tx_data = '0;
  logic cts_n = 0, rx_ack = 0, rxd_drv = 1, loop_en = 0;
  logic tx_ready, txd, tx_active, rts_n, rx_valid, rx_perr, rx_ferr;
  logic [7:0] rx_data;
  logic rxd;
  int checks = 0, errors = 0, cyc = 0;

  assign rxd = loop_en ? txd : rxd_drv;

  always #2 clk = ~clk;

  uart485_core u0 (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .cfg_data7(cfg_data7),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .cfg_flow_off(cfg_flow_off), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .txd(txd), .tx_active(tx_active), .cts_n(cts_n),
    .rts_n(rts_n), .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ack(rx_ack)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, act=%0d exp=<190000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_byte(input logic [7:0] b, input bit d7);
    return d7 ? {1'b0, b[6:0]} : b;
  endfunction

  function automatic bit par_of(input logic [7:0] b, input bit d7, input bit odd);
    return (^mask_byte(b, d7)) ^ odd;
  endfunction

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Samples txd at every bit centre and compares the frame with the expected value.
  task automatic decode_tx(input logic [7:0] b, input bit d7, pe, po, s2, input int bitc);
    logic [7:0] got;
    bit act_ok, start_ok, par_got, stops_ok;
    int nb;
    nb = d7 ? 7 : 8;
    got = '0;
    @(negedge txd);
    clocks(bitc / 2);
    start_ok = (txd == 1'b0);
    act_ok = tx_active;
    for (int i = 0; i < nb; i++) begin
      clocks(bitc);
      got[i] = txd;
      act_ok &= tx_active;
    end
    check(start_ok, "R1 start bit low", txd, 0);
    check(got == mask_byte(b, d7), "R1/R2 data bits LSB first", got, mask_byte(b, d7));
    if (pe) begin
      clocks(bitc);
      par_got = txd;
      check(par_got == par_of(b, d7, po), "R3 parity bit", par_got, par_of(b, d7, po));
    end
    clocks(bitc);
    stops_ok = txd;
    act_ok &= tx_active;
    if (s2) begin
      clocks(bitc);
      stops_ok &= txd;
      act_ok &= tx_active;
    end
    check(stops_ok, "R4 stop bits high", stops_ok, 1);
    check(act_ok, "R7 tx_active over frame", act_ok, 1);
  endtask

  task automatic drive_rx(input logic [7:0] b, input bit d7, pe, po, flip, stop_low, input int per);
    int bitc;
    bitc = 16 * per;
    @(negedge clk);
    rxd_drv = 1'b0;
    clocks(bitc);
    for (int i = 0; i < (d7 ? 7 : 8); i++) begin
      rxd_drv = b[i];
      clocks(bitc);
    end
    if (pe) begin
      rxd_drv = par_of(b, d7, po) ^ flip;
      clocks(bitc);
    end
    if (stop_low) begin
      rxd_drv = 1'b0;
      clocks(12 * per);
    end
    rxd_drv = 1'b1;
    clocks(2 * bitc);
  endtask

  task automatic ack_rx;
    @(negedge clk);
    rx_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_ack = 1'b0;
  endtask

  initial begin
    logic [7:0] b;
    int per;
    bit d7, pe, po, s2, fo;
    void'($urandom(32'h5EED_0485));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clocks(3);
    // R7 R11 R12: reset state
    check(txd == 1'b1, "R7 reset txd", txd, 1);
    check(tx_active == 1'b0, "R7 reset tx_active", tx_active, 0);
    check(rx_valid == 1'b0, "R11 reset rx_valid", rx_valid, 0);
    check(rts_n == 1'b0, "R11 reset rts_n", rts_n, 0);
    check(tx_ready == 1'b1, "R12 reset tx_ready", tx_ready, 1);

    // R5: default 8N1 at the default divisor
    fork
      send_tx(8'hA5);
      decode_tx(8'hA5, 0, 0, 0, 0, 16 * DEF_PER);
    join
    clocks(8 * DEF_PER + 2 * DEF_PER + 4);
    check(tx_active == 1'b0, "R5 default frame ends after one stop", tx_active, 0);

    // R6: CTS gating and completion of a frame in progress
    baud_div = 16'd2;
    @(negedge clk);
    cts_n = 1'b1;
    clocks(4);
    check(tx_ready == 1'b0, "R6 ready low while CTS high", tx_ready, 0);
    tx_data = 8'h3C;
    tx_valid = 1'b1;
    clocks(100);
    check(tx_active == 1'b0, "R6 no start while CTS high", tx_active, 0);
    fork
      decode_tx(8'h3C, 0, 0, 0, 0, 32);
      begin
        cts_n = 1'b0;
        @(posedge tx_active);
        @(negedge clk);
        tx_valid = 1'b0;
        cts_n = 1'b1;
      end
    join
    clocks(24);
    check(tx_active == 1'b0 && tx_ready == 1'b0, "R6 finished, still blocked",
          {tx_active, tx_ready}, 0);
    @(negedge clk);
    cts_n = 1'b0;
    clocks(4);
    check(tx_ready == 1'b1, "R12 ready once CTS low", tx_ready, 1);

    // R1-style random loopback frames over frame formats
    loop_en = 1'b1;
    for (int n = 0; n < 40; n++) begin
      b = 8'($urandom);
      per = 2 + int'($urandom % 3);
      d7 = 1'($urandom); pe = 1'($urandom); po = 1'($urandom);
      s2 = 1'($urandom); fo = 1'($urandom);
      if (n == 0) begin b = 8'hFF; d7 = 1; pe = 1; po = 1; s2 = 1; fo = 0; end
      @(negedge clk);
      baud_div = 16'(per);
      cfg_data7 = d7; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2; cfg_flow_off = fo;
      fork
        send_tx(b);
        decode_tx(b, d7, pe, po, s2, 16 * per);
      join
      clocks(8 * per + 2 * per + 4);
      check(tx_active == 1'b0, "R7 tx_active low after last stop", tx_active, 0);
      check(rx_valid && rx_data == mask_byte(b, d7), "R2 R8 loopback byte",
            {rx_valid, rx_data}, {1'b1, mask_byte(b, d7)});
      check(!rx_perr && !rx_ferr, "R9 R10 clean frame flags", {rx_perr, rx_ferr}, 0);
      check(rts_n == !fo, "R11 rts_n while held", rts_n, !fo);
      ack_rx();
      check(!rx_valid && !rts_n, "R11 cleared by ack", {rx_valid, rts_n}, 0);
    end
    loop_en = 1'b0;

    // R8: short start glitch is rejected
    @(negedge clk);
    baud_div = 16'd2;
    cfg_data7 = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 0; cfg_flow_off = 0;
    rxd_drv = 1'b0;
    clocks(12);
    rxd_drv = 1'b1;
    clocks(3 * 32);
    check(rx_valid == 1'b0, "R8 glitch gives no byte", rx_valid, 0);

    // R10: wrong even parity
    drive_rx(8'h5A, 0, 1, 0, 1, 0, 2);
    check(rx_valid && rx_perr && !rx_ferr, "R10 parity error flagged",
          {rx_valid, rx_perr, rx_ferr}, 3'b110);
    clocks(50);
    check(rx_valid && rx_data == 8'h5A && rts_n, "R11 held until ack",
          {rx_valid, rx_data, rts_n}, {1'b1, 8'h5A, 1'b1});
    ack_rx();

    // R10: correct odd parity, 7 bits
    @(negedge clk);
    cfg_data7 = 1; cfg_par_odd = 1;
    drive_rx(8'h41, 1, 1, 1, 0, 0, 2);
    check(rx_valid && !rx_perr && rx_data == 8'h41, "R10 good odd parity",
          {rx_valid, rx_perr, rx_data}, {2'b10, 8'h41});
    ack_rx();

    // R9: stop bit low
    @(negedge clk);
    cfg_data7 = 0; cfg_par_en = 0;
    drive_rx(8'hC3, 0, 0, 0, 0, 1, 2);
    check(rx_valid && rx_ferr && rx_data == 8'hC3, "R9 framing error flagged",
          {rx_valid, rx_ferr, rx_data}, {2'b11, 8'hC3});
    ack_rx();
    clocks(64);
    check(rx_valid == 1'b0, "R8 no byte from stop-bit tail", rx_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule